// File: doc/BRIEF.md
# Core Voltage Reference Ramp Sequencer

This block produces the digital reference for a core-voltage regulator, an integer count of millivolts that a downstream converter turns into an analog setpoint. A 5-bit voltage-identification code selects the target. When the enable input is high and the supply monitor reports a good supply, the reference starts at zero and climbs slowly. Once it reaches a start threshold, soft start is complete and the climb switches to a slew twenty times faster, which continues until the reference sits exactly on the decoded target.

After soft start the block follows code changes on the fly. It moves the reference up or down at the fast rate and pulses a flag for one cycle on every new code. Two reserved codes mean that no processor is fitted. Either one shuts the ramp down and raises a flag that the power-good logic uses to hold its output low.

The supply monitor takes a digital reading of the supply rail. It uses a hysteresis window, so the ramp does not restart while the rail sits between the two limits. All ports are plain level signals. The code is a static setting and the reference is a continuous level, so there is no handshake at the edge of the block.

Top module: `vref_ramp_seq`

## Requirements
- R1: The target follows from the sampled code `vid`. When bit 4 is 0, the target is 2000 − 50·vid[3:0] mV, for vid[3:0] from 0 to 14. When bit 4 is 1, the target is 1275 − 25·vid[3:0] mV, for vid[3:0] from 0 to 14.
- R2: While the sampled code is 01111 or 11111, `cpu_absent` is 1, `ref_mv` is 0 and `ss_done` is 0. A valid code restarts the sequence from zero at the slow rate.
- R3: The supply is considered good once `vcc_mv` rises strictly above 4500. It is considered bad once `vcc_mv` falls strictly below 4000. Between the two limits the previous state holds.
- R4: Low `en`, or a supply that is not good, sets `ref_mv` to 0 and `ss_done` to 0 at the next clock edge.
- R5: Before `ss_done`, the reference moves by STEP_MV (default 1) once every SLOW_DIV (default 20) cycles.
- R6: `ss_done` rises one cycle after `ref_mv` first reaches 900. It stays high until the block is disabled.
- R7: With `ss_done` high, the reference moves by STEP_MV once every FAST_DIV (default 1) cycles.
- R8: The reference stops exactly on the target, never passes it, and holds there while the code stays the same.
- R9: After soft start, a new code moves the reference toward the new target at the fast rate, in either direction.
- R10: `code_chg` is high for exactly one cycle, the cycle after the sampled code differs from the previously sampled code, and only while the sequence is running.
- R11: After reset, `ref_mv`, `ss_done` and `code_chg` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequence enable; low clears the ramp |
| vcc_mv | input | VCC_W (13) | Supply rail reading in mV |
| vid | input | 5 | Voltage-identification code |
| ref_mv | output | REF_W (12) | Reference in mV |
| ss_done | output | 1 | Soft start complete |
| code_chg | output | 1 | One-cycle pulse on a new code |
| cpu_absent | output | 1 | Reserved no-processor code is present |

## Verification
The assertions assume that `vid` is a synchronous level, that the rail reading stays below 8192, and that every decoded target is above the 900 mV threshold. Because of that last assumption, the reference never falls back under the threshold once `ss_done` is set. The bench changes all inputs only on the falling clock edge and applies only codes from the decode table. It moves the rail reading across both hysteresis limits, including values exactly on each limit, so the comparisons on the boundary are exercised.

// File: rtl/vref_pkg.sv
package vref_pkg;
  localparam int REF_W = 12;
  localparam int VID_W = 5;

  function automatic logic [REF_W-1:0] vid_to_mv(input logic [VID_W-1:0] code);
    int v;
    if (!code[4]) v = 2000 - 50 * int'(code[3:0]);
    else          v = 1275 - 25 * int'(code[3:0]);
    return REF_W'(v);
  endfunction

  function automatic logic vid_absent(input logic [VID_W-1:0] code);
    return code[3:0] == 4'hF;
  endfunction
endpackage

// File: rtl/vcc_hyst.sv
module vcc_hyst #(
  parameter int VCC_W   = 13,
  parameter int RISE_MV = 4500,
  parameter int FALL_MV = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VCC_W-1:0] vcc_mv,
  output logic             supply_ok
);
  localparam logic [VCC_W-1:0] RISE_V = VCC_W'(RISE_MV);
  localparam logic [VCC_W-1:0] FALL_V = VCC_W'(FALL_MV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         supply_ok <= 1'b0;
    else if (supply_ok) supply_ok <= (vcc_mv >= FALL_V);
    else                supply_ok <= (vcc_mv > RISE_V);
  end

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && vcc_mv <= RISE_V) |=> !supply_ok);
  // R3
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && vcc_mv >= FALL_V) |=> supply_ok);
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int SLOW_DIV = 20,
  parameter int FAST_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fast,
  output logic tick
);
  localparam int CW = $clog2(SLOW_DIV + 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = fast ? FAST_LIM : SLOW_LIM;
  assign tick = active && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R5
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0));
endmodule

// File: rtl/ref_slew.sv
module ref_slew #(
  parameter int REF_W   = 12,
  parameter int STEP_MV = 1,
  parameter int TH_MV   = 900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [REF_W-1:0] tgt,
  output logic [REF_W-1:0] ref_q,
  output logic             done_q
);
  localparam logic [REF_W-1:0] STEP_V = REF_W'(STEP_MV);
  localparam logic [REF_W-1:0] TH_V   = REF_W'(TH_MV);

  logic [REF_W-1:0] ref_nx;

  always_comb begin
    ref_nx = ref_q;
    if (ref_q < tgt)
      ref_nx = ((tgt - ref_q) > STEP_V) ? ref_q + STEP_V : tgt;
    else if (ref_q > tgt)
      ref_nx = ((ref_q - tgt) > STEP_V) ? ref_q - STEP_V : tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      done_q <= 1'b0;
    end else if (!run) begin
      ref_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ref_q >= TH_V) done_q <= 1'b1;
      if (tick)          ref_q  <= ref_nx;
    end
  end

  // R8
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ref_q <= tgt) |=> (!run || ref_q <= $past(tgt)));
  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (!run || (ref_q <= $past(ref_q) + STEP_V && ref_q + STEP_V >= $past(ref_q))));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ref_q == '0 && !done_q));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && run) |=> done_q);
endmodule

// File: rtl/vref_ramp_seq.sv
module vref_ramp_seq
  import vref_pkg::*;
#(
  parameter int VCC_W    = 13,
  parameter int RISE_MV  = 4500,
  parameter int FALL_MV  = 4000,
  parameter int SLOW_DIV = 20,
  parameter int FAST_DIV = 1,
  parameter int STEP_MV  = 1,
  parameter int TH_MV    = 900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VCC_W-1:0] vcc_mv,
  input  logic [4:0]       vid,
  output logic [11:0]      ref_mv,
  output logic             ss_done,
  output logic             code_chg,
  output logic             cpu_absent
);
  logic             supply_ok;
  logic             run;
  logic             tick;
  logic [VID_W-1:0] vid_q;
  logic [REF_W-1:0] tgt;

  vcc_hyst #(.VCC_W(VCC_W), .RISE_MV(RISE_MV), .FALL_MV(FALL_MV)) u_hyst (
    .clk(clk), .rst_n(rst_n), .vcc_mv(vcc_mv), .supply_ok(supply_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q      <= '1;
      cpu_absent <= 1'b0;
      code_chg   <= 1'b0;
    end else begin
      vid_q      <= vid;
      cpu_absent <= vid_absent(vid);
      code_chg   <= run && (vid != vid_q);
    end
  end

  assign run = en && supply_ok && !cpu_absent;
  assign tgt = vid_to_mv(vid_q);

  tick_gen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .active(run), .fast(ss_done), .tick(tick));

  ref_slew #(.REF_W(REF_W), .STEP_MV(STEP_MV), .TH_MV(TH_MV)) u_slew (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .tgt(tgt),
    .ref_q(ref_mv), .done_q(ss_done));

  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || $stable(ref_mv)));
  // R2
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_absent |=> (ref_mv == '0 && !ss_done));
  // R10
  chg_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !code_chg);
endmodule

// File: tb/test_vref_ramp_seq.sv
module test_vref_ramp_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [12:0] vcc_mv = '0;
  logic [4:0]  vid = 5'b00100;
  logic [11:0] ref_mv;
  logic        ss_done, code_chg, cpu_absent;

  int nchk = 0, nfail = 0, cyc = 0;

  vref_ramp_seq i_vref_ramp_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .vcc_mv(vcc_mv), .vid(vid),
    .ref_mv(ref_mv), .ss_done(ss_done), .code_chg(code_chg), .cpu_absent(cpu_absent));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_mv(input int c);
    if (c < 16) return 2000 - 50 * (c % 16);
    return 1275 - 25 * (c % 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int v, input int lim, output int n, output int mx, output int mn);
    n = 0; mx = ref_mv; mn = ref_mv;
    while (int'(ref_mv) != v && n < lim) begin
      @(negedge clk);
      n++;
      if (int'(ref_mv) > mx) mx = ref_mv;
      if (int'(ref_mv) < mn) mn = ref_mv;
    end
  endtask

  task automatic t_reset();
    chk(ref_mv == 0, "R11 ref", ref_mv, 0);
    chk(ss_done == 0, "R11 done", ss_done, 0);
    chk(code_chg == 0, "R11 chg", code_chg, 0);
  endtask

  task automatic t_startup();
    int n, mx, mn, bad;
    vid = 5'b00100; vcc_mv = 13'd5000; en = 1'b1;
    wait_ref(100, 5000, n, mx, mn);
    wait_ref(200, 5000, n, mx, mn);
    chk(n == 2000, "R5 slow period", n, 2000);
    wait_ref(899, 20000, n, mx, mn);
    chk(ss_done == 0, "R6 not done below 900", ss_done, 0);
    wait_ref(900, 100, n, mx, mn);
    chk(ss_done == 0, "R6 done lags one cycle", ss_done, 0);
    @(negedge clk);
    chk(ss_done == 1, "R6 done set", ss_done, 1);
    wait_ref(1000, 500, n, mx, mn);
    wait_ref(1100, 500, n, mx, mn);
    chk(n == 100, "R7 fast period", n, 100);
    wait_ref(1800, 2000, n, mx, mn);
    chk(ref_mv == 1800, "R1 R8 settle 00100", ref_mv, 1800);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (ref_mv != 1800) bad++;
    end
    chk(bad == 0, "R8 hold on target", bad, 0);
  endtask

  task automatic t_track();
    int n, mx, mn;
    vid = 5'b00000;
    @(negedge clk);
    chk(code_chg == 1, "R10 pulse high", code_chg, 1);
    @(negedge clk);
    chk(code_chg == 0, "R10 pulse one cycle", code_chg, 0);
    wait_ref(2000, 1000, n, mx, mn);
    chk(ref_mv == 2000 && mx <= 2000, "R9 R8 rise", mx, 2000);
    chk(n <= 205, "R9 rise at fast rate", n, 200);
    vid = 5'b11110;
    wait_ref(925, 2000, n, mx, mn);
    chk(ref_mv == 925 && mn >= 925, "R9 R8 fall", mn, 925);
    chk(n <= 1080, "R9 fall at fast rate", n, 1075);
  endtask

  task automatic t_sweep();
    int n, mx, mn;
    for (int c = 0; c < 32; c++) begin
      if (c == 15 || c == 31) continue;
      vid = 5'(c);
      wait_ref(exp_mv(c), 1500, n, mx, mn);
      chk(int'(ref_mv) == exp_mv(c), $sformatf("R1 code %0d", c), ref_mv, exp_mv(c));
    end
  endtask

  task automatic t_absent();
    vid = 5'b01111;
    repeat (3) @(negedge clk);
    chk(cpu_absent == 1, "R2 absent 01111", cpu_absent, 1);
    chk(ref_mv == 0 && ss_done == 0, "R2 shutdown 01111", ref_mv, 0);
    vid = 5'b11111;
    repeat (3) @(negedge clk);
    chk(cpu_absent == 1 && ref_mv == 0, "R2 shutdown 11111", ref_mv, 0);
    vid = 5'b00100;
    repeat (100) @(negedge clk);
    chk(cpu_absent == 0, "R2 absent cleared", cpu_absent, 0);
    chk(ref_mv > 0 && ref_mv <= 6 && ss_done == 0, "R2 slow restart", ref_mv, 5);
  endtask

  task automatic t_enable();
    int n, mx, mn, pulses;
    wait_ref(1800, 20000, n, mx, mn);
    chk(ss_done == 1, "R6 done before disable", ss_done, 1);
    en = 1'b0;
    @(negedge clk);
    chk(ref_mv == 0 && ss_done == 0, "R4 enable low clears", ref_mv, 0);
    pulses = 0;
    vid = 5'b00001;
    repeat (3) begin
      @(negedge clk);
      if (code_chg) pulses++;
    end
    chk(pulses == 0, "R10 no pulse while stopped", pulses, 0);
    en = 1'b1;
  endtask

  task automatic t_supply();
    repeat (40) @(negedge clk);
    vcc_mv = 13'd4200;
    repeat (30) @(negedge clk);
    chk(ref_mv > 0, "R3 hold between limits", ref_mv, 1);
    vcc_mv = 13'd4000;
    repeat (3) @(negedge clk);
    chk(ref_mv > 0, "R3 at fall limit still good", ref_mv, 1);
    vcc_mv = 13'd3999;
    repeat (3) @(negedge clk);
    chk(ref_mv == 0 && ss_done == 0, "R3 R4 supply low clears", ref_mv, 0);
    vcc_mv = 13'd4500;
    repeat (40) @(negedge clk);
    chk(ref_mv == 0, "R3 at rise limit stays off", ref_mv, 0);
    vcc_mv = 13'd4501;
    repeat (60) @(negedge clk);
    chk(ref_mv > 0, "R3 restart above rise limit", ref_mv, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_startup();
    t_track();
    t_sweep();
    t_absent();
    t_enable();
    t_supply();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule